// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky flags that tell software which event caused the last device reset. It has four event inputs, one for each reset source: power-on, brown-out, external pin and watchdog. Each input is a single-cycle pulse. A pulse sets its flag, and the flag then stays set through any later warm reset. Software reads the flags through a combinational 8-bit read port. It acknowledges a flag by writing a zero to that bit through the write port, which has a write enable and 8 bits of data.

The storage flops take no general system reset. The power-on event is the only thing that wipes history. It sets the power flag and clears the other three in the same cycle. A watchdog, brown-out or pin reset therefore leaves every earlier flag in place. Software should read the register early after boot and then clear it, so that the next reset leaves an unambiguous record. Writes can only clear flags. If an event and a clearing write arrive in the same cycle, the event wins.

Top module: `rst_cause_reg`

## Requirements
- R1: Read bits 7 to 4 are always 0, and write data in bits 7 to 4 has no effect on any flag.
- R2: A cycle with `por_evt` high makes the register read 0x01 after that clock edge (bit 0 = 1, bits 3 to 1 = 0), whatever the other event inputs and the write port carry in that cycle.
- R3: A cycle with `wdt_evt` high and `por_evt` low sets bit 3 at that clock edge.
- R4: A cycle with `bor_evt` high and `por_evt` low sets bit 2 at that clock edge.
- R5: A cycle with `ext_evt` high and `por_evt` low sets bit 1 at that clock edge.
- R6: A write (`wr_en` high) whose data bit k (k = 0 to 3) is 0 clears flag k at that clock edge, provided no event for flag k is active. Bit 0 is cleared only in this way.
- R7: A write whose data bit k is 1 leaves flag k unchanged. A write never sets a flag.
- R8: If the event for flag k (bits 3 to 1) and a write with data bit k = 0 happen in the same cycle without `por_evt`, flag k is 1 after that edge.
- R9: Without `por_evt` and without a clearing write, every flag keeps its value. Brown-out, pin and watchdog events never clear any flag, bit 0 included.
- R10: `rd_data` is a combinational view of the stored flags. During a cycle that carries an event or a write, it shows the value from before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_evt | input | 1 | Power-on reset event pulse |
| bor_evt | input | 1 | Brown-out reset event pulse |
| ext_evt | input | 1 | External pin reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 in bits 3 to 0 clears the matching flag |
| rd_data | output | 8 | Combinational read-back; bits 7 to 4 are zero |

## Verification
The assertions check the per-cycle flag rules on every clock once a power-on event has been seen: the power-on result, each event setting its flag, a set beating a clear, clear-by-zero, write-one having no effect, and flags holding otherwise. Only the bench's scenarios show three further things. The first is that the full flag word matches an arithmetic model across every starting state, every event combination and several write patterns. The second is that the read value lags the stimulus by exactly one edge. The third is that the reserved read bits stay zero while ones are written to them.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  // Register geometry
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_SRC = 4;

  // Flag positions: software decodes these, so they are fixed
  typedef enum int unsigned {
    SRC_POWER = 0,
    SRC_PIN   = 1,
    SRC_BROWN = 2,
    SRC_WDOG  = 3
  } src_e;

endpackage

// File: rtl/rcr_flag_cell.sv
module rcr_flag_cell #(
  parameter bit POWER_BIT = 1'b0
) (
  input  logic clk,
  input  logic por_i,
  input  logic evt_i,
  input  logic clr_i,
  output logic q_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  generate
    if (POWER_BIT) begin : g_power
      // The power event is the only set source; a clearing write is the only clear
      always_comb begin
        flag_en = por_i | evt_i | clr_i;
        flag_d  = por_i | evt_i;
      end
    end else begin : g_warm
      // Power-on wipes this flag; its own event sets it, and a set beats a clear
      always_comb begin
        flag_en = por_i | evt_i | clr_i;
        if (por_i) begin
          flag_d = 1'b0;
        end else if (evt_i) begin
          flag_d = 1'b1;
        end else begin
          flag_d = 1'b0;
        end
      end
    end
  endgenerate

  // No reset on purpose: the flop must survive every warm reset
  always_ff @(posedge clk) begin
    if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign q_o = flag_q;

endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux #(
  parameter int unsigned REG_W   = rcr_pkg::REG_W,
  parameter int unsigned NUM_SRC = rcr_pkg::NUM_SRC
) (
  input  logic [NUM_SRC-1:0] flags_i,
  output logic [REG_W-1:0]   rd_o
);

  localparam int unsigned RSV_W = REG_W - NUM_SRC;

  generate
    if (RSV_W > 0) begin : g_rsv
      always_comb begin
        rd_o = {{RSV_W{1'b0}}, flags_i};
      end
    end else begin : g_full
      always_comb begin
        rd_o = flags_i;
      end
    end
  endgenerate

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int unsigned REG_W   = rcr_pkg::REG_W,
  parameter int unsigned NUM_SRC = rcr_pkg::NUM_SRC
) (
  input  logic             clk,
  input  logic             por_evt,
  input  logic             bor_evt,
  input  logic             ext_evt,
  input  logic             wdt_evt,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);

  import rcr_pkg::*;

  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] flags;

  // Event vector ordered by flag position
  always_comb begin
    evt_vec            = '0;
    evt_vec[SRC_POWER] = por_evt;
    evt_vec[SRC_PIN]   = ext_evt;
    evt_vec[SRC_BROWN] = bor_evt;
    evt_vec[SRC_WDOG]  = wdt_evt;
  end

  // A written zero requests a clear; a written one requests nothing
  always_comb begin
    clr_vec = {NUM_SRC{wr_en}} & ~wr_data[NUM_SRC-1:0];
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    rcr_flag_cell #(
      .POWER_BIT (k == SRC_POWER)
    ) u_cell (
      .clk   (clk),
      .por_i (por_evt),
      .evt_i (evt_vec[k]),
      .clr_i (clr_vec[k]),
      .q_o   (flags[k])
    );
  end

  rcr_read_mux #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC)
  ) u_rd (
    .flags_i (flags),
    .rd_o    (rd_data)
  );

  // ---------------------------------------------------------------------------
  // Assertions: armed by the first power-on event, since flags have no reset
  // ---------------------------------------------------------------------------
  logic chk_armed_q;
  always_ff @(posedge clk) begin
    if (por_evt) begin
      chk_armed_q <= 1'b1;
    end
  end

  a_r2_power_result: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
    por_evt |=> (flags == NUM_SRC'(1)));

  a_r3_wdog_sets: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
    (wdt_evt && !por_evt) |=> flags[SRC_WDOG]);

  a_r4_brown_sets: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
    (bor_evt && !por_evt) |=> flags[SRC_BROWN]);

  a_r5_pin_sets: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
    (ext_evt && !por_evt) |=> flags[SRC_PIN]);

  // R1: ones in the reserved write bits together with ones in the flag bits change nothing
  a_r1_rsv_write_inert: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
    (wr_en && (|wr_data[REG_W-1:NUM_SRC]) && (&wr_data[NUM_SRC-1:0]) && (evt_vec == '0))
      |=> $stable(flags));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    a_r6_zero_clears: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
      (wr_en && !wr_data[k] && !evt_vec[k] && !por_evt) |=> !flags[k]);

    a_r7_one_inert: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
      (wr_en && wr_data[k] && !flags[k] && !evt_vec[k] && !por_evt) |=> !flags[k]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
      (flags[k] && !por_evt && !(wr_en && !wr_data[k])) |=> flags[k]);

    if (k != SRC_POWER) begin : g_warm_chk
      a_r8_set_wins: assert property (@(posedge clk) disable iff (chk_armed_q !== 1'b1)
        (evt_vec[k] && wr_en && !wr_data[k] && !por_evt) |=> flags[k]);
    end
  end

endmodule

// File: tb/rst_cause_reg_bench.sv
`timescale 1ns/1ps
module rst_cause_reg_bench;

  logic       clk;
  logic       por_evt, bor_evt, ext_evt, wdt_evt;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int checks;
  int failures;
  bit done;

  rst_cause_reg u_rst_cause_reg (
    .clk     (clk),
    .por_evt (por_evt),
    .bor_evt (bor_evt),
    .ext_evt (ext_evt),
    .wdt_evt (wdt_evt),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp_v);
    end
  endtask

  // ev bit order: 0 power, 1 pin, 2 brown-out, 3 watchdog (same as flag positions)
  task automatic apply(input logic [3:0] ev, input logic we, input logic [7:0] d,
                       output logic [7:0] pre);
    @(negedge clk);
    por_evt = ev[0]; ext_evt = ev[1]; bor_evt = ev[2]; wdt_evt = ev[3];
    wr_en = we; wr_data = d;
    #1 pre = rd_data;
    @(negedge clk);
    por_evt = 0; ext_evt = 0; bor_evt = 0; wdt_evt = 0; wr_en = 0; wr_data = 8'h00;
    #1;
  endtask

  // Expected next flags from the requirements
  function automatic logic [3:0] model(input logic [3:0] s, input logic [3:0] ev,
                                       input logic we, input logic [7:0] d);
    logic [3:0] clr;
    logic [3:0] n;
    clr = we ? ~d[3:0] : 4'h0;
    if (ev[0]) n = 4'b0001;                  // R2
    else       n = ev | (s & ~clr);          // R3..R9
    return n;
  endfunction

  function automatic string tag_of(input logic [3:0] ev, input logic we, input logic [7:0] d);
    if (ev[0])                                 return "R2";
    if (we && ((ev & ~d[3:0]) != 4'h0))        return "R8";
    if (ev != 4'h0)                            return "R3/R4/R5/R9";
    if (we)                                    return "R6/R7";
    return "R9";
  endfunction

  task automatic set_state(input logic [3:0] s);
    logic [7:0] pre;
    apply(4'b0001, 1'b0, 8'h00, pre);
    apply({s[3:1], 1'b0}, 1'b0, 8'h00, pre);
    if (!s[0]) apply(4'b0000, 1'b1, 8'hFE, pre);
  endtask

  initial begin
    int unsigned cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pre;
    logic [7:0] wpat [4];
    checks = 0; failures = 0; done = 0;
    por_evt = 0; bor_evt = 0; ext_evt = 0; wdt_evt = 0; wr_en = 0; wr_data = 8'h00;
    wpat[0] = 8'h00; wpat[1] = 8'hFF; wpat[2] = 8'hF0; wpat[3] = 8'hA5;

    // Power-on state
    apply(4'b0001, 1'b0, 8'h00, pre);
    check("R2 power-on state", rd_data, 8'h01);

    // Power event with every other source and an all-zero write
    apply(4'b1111, 1'b1, 8'h00, pre);
    check("R2 power overrides", rd_data, 8'h01);

    // Warm events keep bit 0
    apply(4'b1000, 1'b0, 8'h00, pre);
    check("R3 watchdog sets bit 3", rd_data, 8'h09);
    apply(4'b0100, 1'b0, 8'h00, pre);
    check("R4 brown-out sets bit 2", rd_data, 8'h0D);
    apply(4'b0010, 1'b0, 8'h00, pre);
    check("R5 pin sets bit 1", rd_data, 8'h0F);
    apply(4'b0000, 1'b1, 8'hFF, pre);
    check("R1 reserved read zero after ones", rd_data, 8'h0F);
    apply(4'b0000, 1'b1, 8'hFE, pre);
    check("R6 bit 0 cleared by zero write", rd_data, 8'h0E);

    // Exhaustive sweep: start state x events x write pattern
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        for (int w = 0; w < 5; w++) begin
          logic       we;
          logic [7:0] d;
          logic [3:0] exp_f;
          we = (w != 4);
          d  = (w != 4) ? wpat[w] : 8'h00;
          set_state(4'(s));
          check("R6/R9 setup state", rd_data, {4'h0, 4'(s)});
          apply(4'(e), we, d, pre);
          check("R10 read before edge", pre, {4'h0, 4'(s)});
          exp_f = model(4'(s), 4'(e), we, d);
          check(tag_of(4'(e), we, d), {4'h0, rd_data[3:0]}, {4'h0, exp_f});
          check("R1 reserved bits", {rd_data[7:4], 4'h0}, 8'h00);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule